// File: doc/BRIEF.md
# Countdown Timer Peripheral

This block is a 32-bit down-counting timer that sits on a simple word-addressed register bus and drives one level-sensitive interrupt. Software writes a period, which is stored and also loaded straight into the counter. It then starts or stops counting by writing command bits into a stored control word. Once per clock the running counter steps down by one. When the counter expires, a timeout flag is set. In one-shot mode the counter then halts. In continuous mode it reloads the stored period and keeps running.

A status word reports the timeout flag and whether the counter is running. A write to the status word clears the timeout flag, and the data written has no effect. The live count can be read at any time through a snapshot word. The interrupt output is the timeout flag gated by an enable bit in the control word. Every bus access completes in one cycle, and read data is registered.

Top module: `cdtimer`

## Requirements
- R1: A synchronous reset clears every register to zero and leaves the counter stopped. While reset is high, `irq` and `bus_rdata` are 0.
- R2: The word index is `bus_addr >> 2`. Index 0 is status, 1 is control, 2 is period and 3 is snapshot. Read data appears on `bus_rdata` one clock after the read request and is 0 in every other cycle. Any other index reads as 0, and a write to it changes nothing.
- R3: A control write stores the whole 32-bit value, and reading control returns it. Bit 0 enables the interrupt, bit 1 selects continuous mode, bit 2 commands start and bit 3 commands stop.
- R4: A control write with bit 2 set starts the counter. A control write with bit 3 set halts it. When both bits are set in one write, the counter ends up halted. Status bit 1 reads 1 exactly while the counter runs.
- R5: A period write stores the value and loads it into the counter at the same clock edge.
- R6: A running counter decreases by one per clock. Expiry happens on the step taken from a count of 1, or on the first step from a count of 0. The count is then 0 and status bit 0 (the timeout flag) is set. After a start with period P ≥ 1, the flag is set P clocks after the start write.
- R7: In one-shot mode (control bit 1 clear), the counter stops at expiry.
- R8: In continuous mode, the counter reloads the period at expiry and keeps running.
- R9: Any write to status clears the timeout flag, whatever the data. If an expiry falls in the same cycle, the flag is set.
- R10: `irq` is the timeout flag AND control bit 0. It is registered and changes at the same edge as the flag or the control word.
- R11: Reading snapshot returns the live count. Writes to snapshot are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access request for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Level interrupt |

## Verification
The assertions check the cycle-level rules on every clock:
- the step of one per running cycle;
- the loading of the counter on a period write;
- stop winning over start;
- halting at a one-shot expiry, and reloading at a continuous expiry;
- the timeout flag being set on expiry;
- `irq` tracking the flag and the enable bit.

Only the bench scenarios can show the behaviour visible through the bus:
- the exact number of clocks from a start write to the interrupt;
- the snapshot values seen while the counter runs;
- the register readback, with the data of status and snapshot writes ignored;
- zeros from unmapped offsets;
- recovery from a reset applied mid-count.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  // Register word indices; the order is decoded from bus_addr[3:2].
  typedef enum logic [1:0] {
    REG_STAT   = 2'd0,
    REG_CTRL   = 2'd1,
    REG_PERIOD = 2'd2,
    REG_SNAP   = 2'd3
  } cdt_reg_e;

  localparam int NUM_REGS  = 4;
  // Status bits
  localparam int STAT_TO   = 0;
  localparam int STAT_RUN  = 1;
  // Control bits
  localparam int CTL_IEN   = 0;
  localparam int CTL_CONT  = 1;
  localparam int CTL_START = 2;
  localparam int CTL_STOP  = 3;
endpackage

// File: rtl/cdt_count.sv
module cdt_count #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         start_i,
  input  logic         stop_i,
  input  logic         cont_i,
  input  logic [W-1:0] period_i,
  output logic [W-1:0] count_o,
  output logic         running_o,
  output logic         expire_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         run_q, run_d;
  logic         last_step;

  assign last_step = (cnt_q <= W'(1));
  assign expire_o  = run_q && !load_i && last_step;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)
      cnt_d = load_val_i;
    else if (run_q) begin
      if (last_step)
        cnt_d = cont_i ? period_i : '0;
      else
        cnt_d = cnt_q - W'(1);
    end
  end

  always_comb begin
    run_d = run_q;
    if (expire_o && !cont_i)
      run_d = 1'b0;
    if (start_i)
      run_d = 1'b1;
    if (stop_i)
      run_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  assign count_o   = cnt_q;
  assign running_o = run_q;

  // R6
  cnt_dec_chk: assert property (@(posedge clk) disable iff (rst)
    (run_q && !load_i && cnt_q > W'(1)) |=> (cnt_q == $past(cnt_q) - W'(1)));
  // R5
  cnt_load_chk: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (cnt_q == $past(load_val_i)));
  // R4
  stop_wins_chk: assert property (@(posedge clk) disable iff (rst)
    stop_i |=> !run_q);
  // R4
  start_runs_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && !stop_i) |=> run_q);
  // R7
  oneshot_halt_chk: assert property (@(posedge clk) disable iff (rst)
    (expire_o && !cont_i && !start_i) |=> (!run_q && cnt_q == '0));
  // R8
  cont_reload_chk: assert property (@(posedge clk) disable iff (rst)
    (expire_o && cont_i && !stop_i) |=> (run_q && cnt_q == $past(period_i)));
endmodule

// File: rtl/cdt_regs.sv
module cdt_regs
  import cdt_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] count_i,
  input  logic          running_i,
  input  logic          expire_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o,
  output logic          load_o,
  output logic          start_o,
  output logic          stop_o,
  output logic          cont_o,
  output logic [DW-1:0] period_o
);
  localparam int IW = AW - 2;

  logic [IW-1:0] idx;
  cdt_reg_e      reg_sel;
  logic          hit, wr, rd;
  logic          wr_stat, wr_ctrl, wr_period;
  logic [DW-1:0] ctrl_q, ctrl_d, period_q;
  logic          tflag_q, tflag_d;
  logic          irq_q;
  logic [DW-1:0] rd_val;

  assign idx     = addr_i[AW-1:2];
  assign reg_sel = cdt_reg_e'(idx[1:0]);
  assign hit     = (int'(idx) < NUM_REGS);
  assign wr      = sel_i && we_i && hit;
  assign rd      = sel_i && !we_i;

  assign wr_stat   = wr && (reg_sel == REG_STAT);
  assign wr_ctrl   = wr && (reg_sel == REG_CTRL);
  assign wr_period = wr && (reg_sel == REG_PERIOD);

  assign ctrl_d  = wr_ctrl ? wdata_i : ctrl_q;
  assign tflag_d = expire_i ? 1'b1 : (wr_stat ? 1'b0 : tflag_q);

  always_comb begin
    rd_val = '0;
    if (hit) begin
      unique case (reg_sel)
        REG_STAT: begin
          rd_val[STAT_TO]  = tflag_q;
          rd_val[STAT_RUN] = running_i;
        end
        REG_CTRL:   rd_val = ctrl_q;
        REG_PERIOD: rd_val = period_q;
        REG_SNAP:   rd_val = count_i;
        default:    rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      period_q <= '0;
      tflag_q  <= 1'b0;
      irq_q    <= 1'b0;
      rdata_o  <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      tflag_q <= tflag_d;
      irq_q   <= tflag_d & ctrl_d[CTL_IEN];
      rdata_o <= rd ? rd_val : '0;
      if (wr_period)
        period_q <= wdata_i;
    end
  end

  assign irq_o    = irq_q;
  assign load_o   = wr_period;
  assign start_o  = wr_ctrl && wdata_i[CTL_START];
  assign stop_o   = wr_ctrl && wdata_i[CTL_STOP];
  assign cont_o   = ctrl_q[CTL_CONT];
  assign period_o = period_q;

  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o == (tflag_q && ctrl_q[CTL_IEN]));
  // R9
  flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    expire_i |=> tflag_q);
  // R9
  flag_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_stat && !expire_i) |=> !tflag_q);
  // R2
  rdata_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !rd |=> (rdata_o == '0));
endmodule

// File: rtl/cdtimer.sv
module cdtimer #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic              load, start, stop, cont, running, expire;
  logic [DATA_W-1:0] period, count;

  cdt_regs #(.DW(DATA_W), .AW(ADDR_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .sel_i     (bus_sel),
    .we_i      (bus_we),
    .addr_i    (bus_addr),
    .wdata_i   (bus_wdata),
    .count_i   (count),
    .running_i (running),
    .expire_i  (expire),
    .rdata_o   (bus_rdata),
    .irq_o     (irq),
    .load_o    (load),
    .start_o   (start),
    .stop_o    (stop),
    .cont_o    (cont),
    .period_o  (period)
  );

  cdt_count #(.W(DATA_W)) u_count (
    .clk        (clk),
    .rst        (rst),
    .load_i     (load),
    .load_val_i (bus_wdata),
    .start_i    (start),
    .stop_i     (stop),
    .cont_i     (cont),
    .period_i   (period),
    .count_o    (count),
    .running_o  (running),
    .expire_o   (expire)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!irq && bus_rdata == '0));
endmodule

// File: tb/cdtimer_bench.sv
module cdtimer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_sel = 1'b0;
  logic          bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cdtimer #(.DATA_W(DW), .ADDR_W(AW)) u_cdtimer (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  localparam logic [AW-1:0] A_STAT = 6'h00, A_CTRL = 6'h04,
                            A_PER = 6'h08, A_SNAP = 6'h0C;

  task automatic chk(input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(posedge clk); @(negedge clk);
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
    end
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    while (!irq && n < 1000) begin
      @(posedge clk); @(negedge clk);
      n++;
    end
  endtask

  task automatic t_reset;
    logic [DW-1:0] v;
    chk("R1 irq in reset", {31'b0, irq}, 0);
    chk("R1 rdata in reset", bus_rdata, 0);
    rst = 1'b0;
    rd(A_STAT, v); chk("R1 status", v, 0);
    rd(A_CTRL, v); chk("R1 control", v, 0);
    rd(A_PER, v);  chk("R1 period", v, 0);
    rd(A_SNAP, v); chk("R1 snapshot", v, 0);
  endtask

  task automatic t_oneshot;
    logic [DW-1:0] v; int n;
    wr(A_PER, 7);
    rd(A_SNAP, v); chk("R5 period loads counter", v, 7);
    rd(A_PER, v);  chk("R5 period stored", v, 7);
    wr(A_CTRL, 32'h5);
    wait_irq(n);
    chk("R6 cycles to expiry", n, 7);
    rd(A_STAT, v); chk("R7 one-shot halts, flag set", v, 32'h1);
    rd(A_SNAP, v); chk("R6 count at zero", v, 0);
    chk("R10 irq high", {31'b0, irq}, 1);
    wr(A_STAT, 32'hFFFF_FFFF);
    chk("R10 irq clears with flag", {31'b0, irq}, 0);
    rd(A_STAT, v); chk("R9 status write clears flag", v, 0);
  endtask

  task automatic t_continuous;
    logic [DW-1:0] v, v2; int n;
    wr(A_PER, 5);
    wr(A_CTRL, 32'h7);
    wait_irq(n);
    chk("R8 first expiry", n, 5);
    rd(A_STAT, v); chk("R8 still running after expiry", v, 32'h3);
    wr(A_STAT, 32'h0);
    chk("R9 flag cleared by zero write", {31'b0, irq}, 0);
    wait_irq(n);
    chk("R8 reload then second expiry", n, 3);
    wr(A_CTRL, 32'hA);
    chk("R10 enable off gates irq", {31'b0, irq}, 0);
    rd(A_SNAP, v); idle(4); rd(A_SNAP, v2);
    chk("R4 stop freezes count", v2, v);
    rd(A_STAT, v); chk("R4 stopped, flag kept", v, 32'h1);
    wr(A_CTRL, 32'h1);
    chk("R10 enable raises irq", {31'b0, irq}, 1);
    wr(A_STAT, 32'h0);
  endtask

  task automatic t_start_stop;
    logic [DW-1:0] v;
    wr(A_PER, 20);
    wr(A_CTRL, 32'hC);
    idle(3);
    rd(A_STAT, v); chk("R4 start+stop ends halted", v, 0);
    rd(A_SNAP, v); chk("R4 count unchanged", v, 20);
  endtask

  task automatic t_zero_period;
    logic [DW-1:0] v; int n;
    wr(A_PER, 0);
    wr(A_CTRL, 32'h5);
    wait_irq(n);
    chk("R6 zero period expires at first step", n, 1);
    rd(A_STAT, v); chk("R7 zero period halts", v, 32'h1);
    wr(A_STAT, 0);
  endtask

  task automatic t_ignored;
    logic [DW-1:0] v;
    wr(A_CTRL, 32'h0);
    wr(A_PER, 9);
    wr(A_SNAP, 32'h1234);
    rd(A_SNAP, v); chk("R11 snapshot write ignored", v, 9);
    wr(6'h10, 32'hFFFF_FFFF);
    wr(6'h3C, 32'hFFFF_FFFF);
    rd(6'h10, v); chk("R2 unmapped read zero", v, 0);
    rd(6'h24, v); chk("R2 unmapped read zero", v, 0);
    rd(A_PER, v); chk("R2 unmapped write no effect", v, 9);
    rd(A_CTRL, v); chk("R2 unmapped write no effect", v, 0);
    rd(A_STAT, v); chk("R2 unmapped write no effect", v, 0);
    chk("R2 idle rdata zero", bus_rdata, 0);
  endtask

  task automatic t_ctrl_store;
    logic [DW-1:0] v;
    wr(A_CTRL, 32'hDEAD_BEF0);
    rd(A_CTRL, v); chk("R3 control full readback", v, 32'hDEAD_BEF0);
    rd(A_STAT, v); chk("R3 no command bits, stays stopped", v, 0);
  endtask

  task automatic t_live_reset;
    logic [DW-1:0] v;
    wr(A_PER, 100);
    wr(A_CTRL, 32'h4);
    rd(A_SNAP, v); chk("R11 live count first", v, 100);
    rd(A_SNAP, v); chk("R11 live count steps", v, 99);
    rst = 1'b1; idle(2); rst = 1'b0;
    idle(3);
    rd(A_SNAP, v); chk("R1 reset stops counter", v, 0);
    rd(A_STAT, v); chk("R1 reset status", v, 0);
    rd(A_PER, v);  chk("R1 reset period", v, 0);
  endtask

  initial begin
    idle(3);
    t_reset();
    t_oneshot();
    t_continuous();
    t_start_stop();
    t_zero_period();
    t_ignored();
    t_ctrl_store();
    t_live_reset();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule